// File: doc/BRIEF.md
# Packed Lane Shuffle Unit

This block rearranges the lanes of two packed 64-bit source vectors, `vs` and `vt`, into a single 64-bit result. It is meant to sit beside a packed-integer datapath and serve its permute operations. A 2-bit format code selects between eight unsigned byte lanes and four halfword lanes. A 3-bit pattern code then selects one of a fixed set of lane arrangements: interleave of the upper or lower halves, pack of odd or even lanes, a butterfly swap, replication of upper or lower lane pairs, and, in byte mode, an unpack that pairs each low `vs` byte with a sign-fill byte.

The permutation is purely combinational. The result is captured in an output register when the caller pulses `valid_i`, and `done_o` is high in the cycle that follows. A format or pattern code with no meaning drives an all-zero result and raises `illegal_o`. No arithmetic or saturation takes place here.

Top module: `lane_shuffle_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `result_o`, `done_o` and `illegal_o` are all zero.
- R2: A request with `valid_i` high at a rising edge loads `result_o` and `illegal_o` at that edge, and `done_o` is high for exactly that following cycle. Without `valid_i`, `result_o` and `illegal_o` keep their values and `done_o` is low.
- R3: Halfword format (`fmt_i` = 01), where halfword k occupies bits 16k+15:16k. Pattern 0 (interleave-high) yields result halfwords 0..3 = vt2, vs2, vt3, vs3. Pattern 1 (interleave-low) yields vt0, vs0, vt1, vs1.
- R4: Halfword pattern 2 (pack-odd) yields vt1, vt3, vs1, vs3. Pattern 3 (butterfly) yields vt1, vs0, vt3, vs2.
- R5: Halfword pattern 4 (replicate-upper) yields vt2, vt3, vs2, vs3. Pattern 5 (replicate-lower) yields vt0, vt1, vs0, vs1.
- R6: Byte format (`fmt_i[0]` = 0), where byte k occupies bits 8k+7:8k. Pattern 1 (pack-odd) yields result bytes 0..7 = vt1, vt3, vt5, vt7, vs1, vs3, vs5, vs7. Pattern 2 (pack-even) yields vt0, vt2, vt4, vt6, vs0, vs2, vs4, vs6.
- R7: Byte pattern 3 (interleave-high) yields vt4, vs4, vt5, vs5, vt6, vs6, vt7, vs7. Pattern 4 (interleave-low) yields vt0, vs0, vt1, vs1, vt2, vs2, vt3, vs3.
- R8: Byte pattern 0 (signed unpack) sets result byte 2k to vs byte k and byte 2k+1 to 0xFF when bit 7 of vs byte k is 1, or 0x00 when it is 0, for k = 0..3.
- R9: Halfword patterns 6 and 7, byte patterns 5 to 7, and format code 11 are illegal. An illegal request loads an all-zero result and sets `illegal_o`. A later legal request clears `illegal_o`.
- R10: Format codes 00 and 10 both select byte format and give identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe; captures the shuffle result |
| fmt_i | input | 2 | Format code: 01 selects halfword, x0 selects byte, 11 is illegal |
| op_i | input | 3 | Pattern code |
| vs_i | input | 64 | First source vector |
| vt_i | input | 64 | Second source vector |
| result_o | output | 64 | Registered shuffle result |
| done_o | output | 1 | One-cycle pulse after each request |
| illegal_o | output | 1 | Registered flag for an undefined format or pattern |

## Verification
The bench aims at lane-index mistakes. Swapping vs and vt, or an off-by-one in the pack or replicate index, shows up as a wrong byte at a known lane position, because every source byte carries a distinct value. Signed unpack is driven with bytes 0x80, 0x7F, 0xFF and 0x00. A fill taken from the wrong bit, or taken from vt, gives the wrong fill byte. Illegal codes are interleaved with legal ones, so a design that keeps stale data instead of zero, or that leaves the flag stuck, fails. Idle gaps between requests expose a design that does not hold its result, or that stretches or repeats the done pulse.

// File: rtl/shuf_pkg.sv
package shuf_pkg;

    localparam int VEC_W      = 64;
    localparam int BYTE_W     = 8;
    localparam int N_BYTES    = VEC_W / BYTE_W;
    localparam int HALF_BYTES = 2;
    localparam int N_HALVES   = N_BYTES / HALF_BYTES;
    localparam int IDX_W      = $clog2(N_BYTES);

    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_VS   = 2'd1,
        SRC_VT   = 2'd2,
        SRC_SIGN = 2'd3
    } src_e;

    typedef struct packed {
        src_e             src;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef enum logic [1:0] {
        FMT_BYTE = 2'd0,
        FMT_HALF = 2'd1,
        FMT_BAD  = 2'd2
    } fmt_e;

    // halfword pattern codes
    localparam logic [2:0] H_MIXH = 3'd0;
    localparam logic [2:0] H_MIXL = 3'd1;
    localparam logic [2:0] H_PCKO = 3'd2;
    localparam logic [2:0] H_BFLY = 3'd3;
    localparam logic [2:0] H_REPU = 3'd4;
    localparam logic [2:0] H_REPL = 3'd5;

    // byte pattern codes
    localparam logic [2:0] B_UNPK = 3'd0;
    localparam logic [2:0] B_PCKO = 3'd1;
    localparam logic [2:0] B_PCKE = 3'd2;
    localparam logic [2:0] B_MIXH = 3'd3;
    localparam logic [2:0] B_MIXL = 3'd4;

    function automatic fmt_e decode_fmt(input logic [1:0] code);
        if (code == 2'b01)
            return FMT_HALF;
        else if (code[0] == 1'b0)
            return FMT_BYTE;
        else
            return FMT_BAD;
    endfunction

    function automatic logic op_legal(input fmt_e f, input logic [2:0] op);
        case (f)
            FMT_HALF: return op <= H_REPL;
            FMT_BYTE: return op <= B_MIXL;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic pick_t mk_pick(input src_e s, input int idx);
        pick_t p;
        p.src = s;
        p.idx = IDX_W'(idx);
        return p;
    endfunction

    // source of halfword lane 'lane' (index counted in halfwords)
    function automatic pick_t half_pick(input logic [2:0] op, input int lane);
        logic even;
        logic lower;
        even  = (lane % 2) == 0;
        lower = lane < (N_HALVES / 2);
        case (op)
            H_MIXH: return mk_pick(even ? SRC_VT : SRC_VS, N_HALVES / 2 + lane / 2);
            H_MIXL: return mk_pick(even ? SRC_VT : SRC_VS, lane / 2);
            H_PCKO: return mk_pick(lower ? SRC_VT : SRC_VS, 2 * (lane % 2) + 1);
            H_BFLY: return even ? mk_pick(SRC_VT, lane + 1) : mk_pick(SRC_VS, lane - 1);
            H_REPU: return mk_pick(lower ? SRC_VT : SRC_VS, N_HALVES / 2 + lane % 2);
            H_REPL: return mk_pick(lower ? SRC_VT : SRC_VS, lane % 2);
            default: return mk_pick(SRC_ZERO, 0);
        endcase
    endfunction

    // source of byte lane 'lane'
    function automatic pick_t byte_pick(input logic [2:0] op, input int lane);
        logic even;
        logic lower;
        int   half_n;
        half_n = N_BYTES / 2;
        even   = (lane % 2) == 0;
        lower  = lane < half_n;
        case (op)
            B_UNPK: return mk_pick(even ? SRC_VS : SRC_SIGN, lane / 2);
            B_PCKO: return mk_pick(lower ? SRC_VT : SRC_VS, 2 * (lane % half_n) + 1);
            B_PCKE: return mk_pick(lower ? SRC_VT : SRC_VS, 2 * (lane % half_n));
            B_MIXH: return mk_pick(even ? SRC_VT : SRC_VS, half_n + lane / 2);
            B_MIXL: return mk_pick(even ? SRC_VT : SRC_VS, lane / 2);
            default: return mk_pick(SRC_ZERO, 0);
        endcase
    endfunction

endpackage

// File: rtl/shuf_decode.sv
module shuf_decode
    import shuf_pkg::*;
(
    input  logic [1:0]              fmt_code_i,
    input  logic [2:0]              op_i,
    output pick_t [N_BYTES-1:0]     picks_o,
    output logic                    illegal_o
);

    fmt_e fmt;
    logic legal;

    always_comb begin
        fmt       = decode_fmt(fmt_code_i);
        legal     = op_legal(fmt, op_i);
        illegal_o = !legal;
    end

    for (genvar j = 0; j < N_BYTES; j++) begin : g_byte
        always_comb begin
            pick_t hp;
            pick_t bp;
            hp = half_pick(op_i, j / HALF_BYTES);
            bp = byte_pick(op_i, j);
            if (!legal) begin
                picks_o[j] = mk_pick(SRC_ZERO, 0);
            end else if (fmt == FMT_HALF) begin
                picks_o[j] = mk_pick(hp.src, int'(hp.idx) * HALF_BYTES + j % HALF_BYTES);
            end else begin
                picks_o[j] = bp;
            end
        end
    end

endmodule

// File: rtl/shuf_lane_mux.sv
module shuf_lane_mux
    import shuf_pkg::*;
(
    input  pick_t [N_BYTES-1:0]  picks_i,
    input  logic  [VEC_W-1:0]    vs_i,
    input  logic  [VEC_W-1:0]    vt_i,
    output logic  [VEC_W-1:0]    data_o
);

    for (genvar j = 0; j < N_BYTES; j++) begin : g_lane
        logic [BYTE_W-1:0] vs_b;
        logic [BYTE_W-1:0] vt_b;

        always_comb begin
            vs_b = vs_i[int'(picks_i[j].idx) * BYTE_W +: BYTE_W];
            vt_b = vt_i[int'(picks_i[j].idx) * BYTE_W +: BYTE_W];
            case (picks_i[j].src)
                SRC_VS:   data_o[j*BYTE_W +: BYTE_W] = vs_b;
                SRC_VT:   data_o[j*BYTE_W +: BYTE_W] = vt_b;
                SRC_SIGN: data_o[j*BYTE_W +: BYTE_W] = {BYTE_W{vs_b[BYTE_W-1]}};
                default:  data_o[j*BYTE_W +: BYTE_W] = '0;
            endcase
        end
    end

endmodule

// File: rtl/shuf_out_reg.sv
module shuf_out_reg
    import shuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [VEC_W-1:0] data_i,
    input  logic             illegal_i,
    output logic [VEC_W-1:0] data_o,
    output logic             illegal_o,
    output logic             done_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o    <= '0;
            illegal_o <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            done_o <= load_i;
            if (load_i) begin
                data_o    <= data_i;
                illegal_o <= illegal_i;
            end
        end
    end

endmodule

// File: rtl/lane_shuffle_unit.sv
module lane_shuffle_unit
    import shuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [1:0]       fmt_i,
    input  logic [2:0]       op_i,
    input  logic [VEC_W-1:0] vs_i,
    input  logic [VEC_W-1:0] vt_i,
    output logic [VEC_W-1:0] result_o,
    output logic             done_o,
    output logic             illegal_o
);

    pick_t [N_BYTES-1:0] picks;
    logic                bad_code;
    logic [VEC_W-1:0]    shuffled;

    shuf_decode i_decode (
        .fmt_code_i (fmt_i),
        .op_i       (op_i),
        .picks_o    (picks),
        .illegal_o  (bad_code)
    );

    shuf_lane_mux i_mux (
        .picks_i (picks),
        .vs_i    (vs_i),
        .vt_i    (vt_i),
        .data_o  (shuffled)
    );

    shuf_out_reg i_oreg (
        .clk       (clk),
        .rst       (rst),
        .load_i    (valid_i),
        .data_i    (shuffled),
        .illegal_i (bad_code),
        .data_o    (result_o),
        .illegal_o (illegal_o),
        .done_o    (done_o)
    );

endmodule

// File: rtl/shuf_checker.sv
module shuf_checker
    import shuf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             valid_i,
    input logic [1:0]       fmt_i,
    input logic [2:0]       op_i,
    input logic [VEC_W-1:0] vs_i,
    input logic [VEC_W-1:0] vt_i,
    input logic [VEC_W-1:0] result_o,
    input logic             done_o,
    input logic             illegal_o
);

    a_r2_done_after_valid: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> done_o);

    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !done_o);

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(result_o) && $stable(illegal_o)));

    a_r9_illegal_gives_zero: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (result_o == '0));

    a_r9_bad_format_flagged: assert property (@(posedge clk) disable iff (rst)
        (valid_i && fmt_i == 2'b11) |=> illegal_o);

    a_r8_sign_fill_low: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !fmt_i[0] && op_i == 3'd0) |=>
            (result_o[15:8] == {8{$past(vs_i[7])}}));

    a_r3_mixl_lane0: assert property (@(posedge clk) disable iff (rst)
        (valid_i && fmt_i == 2'b01 && op_i == 3'd1) |=>
            (result_o[15:0] == $past(vt_i[15:0])));

endmodule

bind lane_shuffle_unit shuf_checker i_shuf_checker (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .fmt_i     (fmt_i),
    .op_i      (op_i),
    .vs_i      (vs_i),
    .vt_i      (vt_i),
    .result_o  (result_o),
    .done_o    (done_o),
    .illegal_o (illegal_o)
);

// File: tb/test_lane_shuffle_unit.sv
module test_lane_shuffle_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [1:0]  fmt_i = 2'b00;
    logic [2:0]  op_i = 3'd0;
    logic [63:0] vs_i = '0;
    logic [63:0] vt_i = '0;
    logic [63:0] result_o;
    logic        done_o;
    logic        illegal_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit started = 0;

    logic [63:0] exp_res = '0;
    logic        exp_done = 1'b0;
    logic        exp_ill = 1'b0;
    logic        exp_in_rst = 1'b1;
    string       exp_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_shuffle_unit i_lane_shuffle_unit (
        .clk       (clk),
        .rst       (rst),
        .valid_i   (valid_i),
        .fmt_i     (fmt_i),
        .op_i      (op_i),
        .vs_i      (vs_i),
        .vt_i      (vt_i),
        .result_o  (result_o),
        .done_o    (done_o),
        .illegal_o (illegal_o)
    );

    function automatic string req_of(logic [1:0] f, logic [2:0] op);
        if (f == 2'b11) return "R9";
        if (f == 2'b01) begin
            case (op)
                3'd0, 3'd1: return "R3";
                3'd2, 3'd3: return "R4";
                3'd4, 3'd5: return "R5";
                default:    return "R9";
            endcase
        end
        case (op)
            3'd0:       return "R8";
            3'd1, 3'd2: return "R6";
            3'd3, 3'd4: return "R7";
            default:    return "R9";
        endcase
    endfunction

    // behavioural reference: returns {illegal, result}
    function automatic logic [64:0] ref_model(logic [1:0] f, logic [2:0] op,
                                              logic [63:0] s, logic [63:0] t);
        logic [7:0]  sb [8];
        logic [7:0]  tb [8];
        logic [7:0]  rb [8];
        logic [15:0] sh [4];
        logic [15:0] th [4];
        logic [15:0] rh [4];
        logic [63:0] r;
        logic        bad;
        bad = 1'b0;
        r = '0;
        for (int k = 0; k < 8; k++) begin
            sb[k] = s[8*k +: 8];
            tb[k] = t[8*k +: 8];
            rb[k] = 8'h00;
        end
        for (int k = 0; k < 4; k++) begin
            sh[k] = s[16*k +: 16];
            th[k] = t[16*k +: 16];
            rh[k] = 16'h0000;
        end
        if (f == 2'b11) begin
            bad = 1'b1;
        end else if (f == 2'b01) begin
            case (op)
                3'd0: begin rh[0] = th[2]; rh[1] = sh[2]; rh[2] = th[3]; rh[3] = sh[3]; end
                3'd1: begin rh[0] = th[0]; rh[1] = sh[0]; rh[2] = th[1]; rh[3] = sh[1]; end
                3'd2: begin rh[0] = th[1]; rh[1] = th[3]; rh[2] = sh[1]; rh[3] = sh[3]; end
                3'd3: begin rh[0] = th[1]; rh[1] = sh[0]; rh[2] = th[3]; rh[3] = sh[2]; end
                3'd4: begin rh[0] = th[2]; rh[1] = th[3]; rh[2] = sh[2]; rh[3] = sh[3]; end
                3'd5: begin rh[0] = th[0]; rh[1] = th[1]; rh[2] = sh[0]; rh[3] = sh[1]; end
                default: bad = 1'b1;
            endcase
            for (int k = 0; k < 4; k++) r[16*k +: 16] = rh[k];
        end else begin
            case (op)
                3'd0: for (int k = 0; k < 4; k++) begin
                          rb[2*k]   = sb[k];
                          rb[2*k+1] = sb[k][7] ? 8'hFF : 8'h00;
                      end
                3'd1: for (int k = 0; k < 4; k++) begin
                          rb[k]   = tb[2*k+1];
                          rb[k+4] = sb[2*k+1];
                      end
                3'd2: for (int k = 0; k < 4; k++) begin
                          rb[k]   = tb[2*k];
                          rb[k+4] = sb[2*k];
                      end
                3'd3: for (int k = 0; k < 4; k++) begin
                          rb[2*k]   = tb[k+4];
                          rb[2*k+1] = sb[k+4];
                      end
                3'd4: for (int k = 0; k < 4; k++) begin
                          rb[2*k]   = tb[k];
                          rb[2*k+1] = sb[k];
                      end
                default: bad = 1'b1;
            endcase
            for (int k = 0; k < 8; k++) r[8*k +: 8] = rb[k];
        end
        if (bad) r = '0;
        return {bad, r};
    endfunction

    // cycle model, updated on every rising edge
    always @(posedge clk) begin
        logic [64:0] m;
        started <= 1'b1;
        if (rst) begin
            exp_res    <= '0;
            exp_done   <= 1'b0;
            exp_ill    <= 1'b0;
            exp_in_rst <= 1'b1;
        end else begin
            exp_in_rst <= 1'b0;
            exp_done   <= valid_i;
            if (valid_i) begin
                m = ref_model(fmt_i, op_i, vs_i, vt_i);
                exp_res <= m[63:0];
                exp_ill <= m[64];
                exp_tag <= req_of(fmt_i, op_i);
            end
        end
    end

    // comparison on every falling edge
    always @(negedge clk) begin
        if (started && !finished) begin
            checks += 3;
            if (done_o !== exp_done) begin
                errors++;
                $display("FAIL %s done_o actual=%0b expected=%0b",
                         exp_in_rst ? "R1" : "R2", done_o, exp_done);
            end
            if (illegal_o !== exp_ill) begin
                errors++;
                $display("FAIL %s illegal_o actual=%0b expected=%0b",
                         exp_in_rst ? "R1" : "R9", illegal_o, exp_ill);
            end
            if (result_o !== exp_res) begin
                errors++;
                $display("FAIL %s result_o actual=%h expected=%h",
                         exp_in_rst ? "R1" : exp_tag, result_o, exp_res);
            end
        end
    end

    task automatic issue(logic [1:0] f, logic [2:0] op, logic [63:0] s, logic [63:0] t);
        @(negedge clk);
        valid_i = 1'b1;
        fmt_i   = f;
        op_i    = op;
        vs_i    = s;
        vt_i    = t;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    localparam logic [63:0] VS_A = 64'hA7A6_A5A4_A3A2_A1A0;
    localparam logic [63:0] VT_A = 64'hB7B6_B5B4_B3B2_B1B0;
    localparam logic [63:0] VS_B = 64'h1122_3344_5566_7788;
    localparam logic [63:0] VT_B = 64'h99AA_BBCC_DDEE_F00F;

    initial begin
        // R1: reset state observed by the compare process
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(2);

        // R3, R4, R5: halfword patterns
        for (int op = 0; op < 6; op++) begin
            issue(2'b01, 3'(op), VS_A, VT_A);
            issue(2'b01, 3'(op), VS_B, VT_B);
        end
        // R6, R7, R8: byte patterns
        for (int op = 0; op < 5; op++) begin
            issue(2'b00, 3'(op), VS_A, VT_A);
            issue(2'b00, 3'(op), VS_B, VT_B);
        end
        // R8: sign fill corners
        issue(2'b00, 3'd0, 64'h0000_0000_00FF_7F80, VT_A);
        issue(2'b00, 3'd0, 64'h0000_0000_807F_00FF, VT_B);
        // R10: format 10 behaves as byte
        for (int op = 0; op < 5; op++) issue(2'b10, 3'(op), VS_B, VT_A);
        // R9: illegal codes then recovery
        issue(2'b01, 3'd6, VS_A, VT_A);
        issue(2'b01, 3'd1, VS_A, VT_A);
        issue(2'b01, 3'd7, VS_B, VT_B);
        issue(2'b00, 3'd5, VS_A, VT_A);
        issue(2'b10, 3'd7, VS_A, VT_A);
        issue(2'b11, 3'd1, VS_A, VT_A);
        idle(3);
        issue(2'b00, 3'd4, VS_A, VT_A);
        // R2: hold across idle gap, then back-to-back requests
        idle(5);
        @(negedge clk);
        valid_i = 1'b1; fmt_i = 2'b01; op_i = 3'd3; vs_i = VS_B; vt_i = VT_A;
        @(negedge clk);
        fmt_i = 2'b00; op_i = 3'd0; vs_i = 64'h8070_6050_4030_2010;
        @(negedge clk);
        fmt_i = 2'b11;
        @(negedge clk);
        valid_i = 1'b0;
        idle(2);
        // mixed stream
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            valid_i = ($urandom % 3) != 0;
            fmt_i   = 2'($urandom);
            op_i    = 3'($urandom);
            vs_i    = {$urandom, $urandom};
            vt_i    = {$urandom, $urandom};
        end
        @(negedge clk);
        valid_i = 1'b0;
        idle(3);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule